// File: doc/BRIEF.md
# Host/Microcontroller Mailbox Bridge

This block is a bank of byte-wide mailbox registers shared between a host I/O bus and an embedded 8-bit microcontroller. The host reaches the bank through a pair of I/O ports at a programmable base address. The even port selects a mailbox number and the odd port reads or writes the selected mailbox. The microcontroller sees the same bank as a plain memory window that starts at address 0x7F00.

A small configuration section gates the host side. It holds an enable bit and a two-byte port base. While the enable bit is clear, no host address decodes. The base is always even and must lie below 0x1000.

Two mailboxes carry doorbells. A host write to mailbox 0 raises an interrupt toward the microcontroller. That interrupt drops when the microcontroller reads mailbox 0. A microcontroller write to mailbox 1 raises an interrupt toward the host. That interrupt drops when the host reads mailbox 1 through the data port.

Top module: `mbx_bridge`

## Requirements
- R1: After reset the following are all zero: the enable bit, both base bytes, the host index, every mailbox and both interrupt outputs.
- R2: While the enable bit is 0, no host address decodes. `host_hit_o` stays low, host reads return 0 and host writes change nothing.
- R3: The configuration register at index 0x30 bit 0 is the enable bit, and its other bits read 0. Index 0x60 is the base high byte. Index 0x61 is the base low byte, and its bit 0 is forced to 0. All other configuration indices read 0.
- R4: A host address above 0x0FFF never decodes, whatever the base is programmed to.
- R5: A host write to base+0 loads the index, and a read of base+0 returns the index. The port at base+1 reads or writes mailbox[index]. An index at or above NUM_MBX reads 0 and ignores writes.
- R6: Microcontroller address 0x7F00+i accesses mailbox i for i < NUM_MBX. Reads outside that window return 0, and writes outside it are ignored.
- R7: A host data-port write to mailbox 0 sets `mcu_irq_o` from the next cycle. A microcontroller read of 0x7F00 clears it from the next cycle.
- R8: A microcontroller write to 0x7F01 sets `host_irq_o` from the next cycle. A host data-port read with index 1 clears it from the next cycle.
- R9: When the host and the microcontroller write the same mailbox in the same cycle, the host data is stored.
- R10: When an interrupt flag is set and cleared in the same cycle, it ends up set.
- R11: Read data and `host_hit_o` are combinational in the cycle of the access. Read data is 0 when no read strobe is active. Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data at cfg_idx_i |
| host_addr_i | input | 16 | Host I/O address |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data |
| host_hit_o | output | 1 | Host address falls in the decoded port pair |
| mcu_addr_i | input | 16 | Microcontroller address |
| mcu_rd_i | input | 1 | Microcontroller read strobe |
| mcu_wr_i | input | 1 | Microcontroller write strobe |
| mcu_wdata_i | input | 8 | Microcontroller write data |
| mcu_rdata_o | output | 8 | Microcontroller read data |
| mcu_irq_o | output | 1 | Doorbell toward the microcontroller |
| host_irq_o | output | 1 | Doorbell toward the host |

## Verification
Decode, host read data, microcontroller read data and configuration read data are due in the same cycle as the strobe. Stored contents, the index and both doorbells change at the following rising edge. The bench drives inputs on the falling edge and compares every output against a behavioural model 1 ns later. At that point the combinational results reflect the new inputs, and the registered results reflect the edge just past. The model is updated on the rising edge from the inputs that were held across it. Because of this, the same-cycle set/clear and write-collision cases are compared in the cycle after they occur.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [15:0] MCU_WIN_BASE = 16'h7F00;
  localparam logic [7:0]  CFG_ENABLE   = 8'h30;
  localparam logic [7:0]  CFG_BASE_HI  = 8'h60;
  localparam logic [7:0]  CFG_BASE_LO  = 8'h61;
  localparam logic [15:0] HOST_LIMIT   = 16'h1000;

  typedef struct packed {
    logic       we;
    logic       re;
    logic [7:0] idx;
    logic [7:0] wdata;
  } mbx_req_t;
endpackage

// File: rtl/mbx_cfg.sv
module mbx_cfg
  import mbx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        enable_o,
  output logic [15:0] base_o
);
  logic       enable_q;
  logic [7:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (we_i) begin
      unique case (idx_i)
        CFG_ENABLE:  enable_q <= wdata_i[0];
        CFG_BASE_HI: hi_q     <= wdata_i;
        CFG_BASE_LO: lo_q     <= {wdata_i[7:1], 1'b0};
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (idx_i)
      CFG_ENABLE:  rdata_o = {7'b0, enable_q};
      CFG_BASE_HI: rdata_o = hi_q;
      CFG_BASE_LO: rdata_o = lo_q;
      default:     rdata_o = '0;
    endcase
  end

  assign enable_o = enable_q;
  assign base_o   = {hi_q, lo_q};

  a_r3_base_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == CFG_BASE_LO) |=> (base_o[0] == 1'b0 && base_o[7:1] == $past(wdata_i[7:1])));
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic [15:0] base_i,
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  input  logic [7:0]  mbx_rdata_i,
  output logic        hit_o,
  output logic [7:0]  rdata_o,
  output mbx_req_t    req_o
);
  logic [7:0] idx_q;
  logic       in_range, idx_wr;

  assign in_range = addr_i < HOST_LIMIT;
  assign hit_o    = enable_i && in_range && (addr_i[15:1] == base_i[15:1]);
  assign idx_wr   = hit_o && wr_i && !addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_wr) idx_q <= wdata_i;
  end

  always_comb begin
    req_o.we    = hit_o && wr_i && addr_i[0];
    req_o.re    = hit_o && rd_i && addr_i[0];
    req_o.idx   = idx_q;
    req_o.wdata = wdata_i;
  end

  always_comb begin
    if (hit_o && rd_i) rdata_o = addr_i[0] ? mbx_rdata_i : idx_q;
    else               rdata_o = '0;
  end

  a_r5_index_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr |=> $stable(idx_q));
  a_r5_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> (idx_q == $past(wdata_i)));
endmodule

// File: rtl/mbx_mcu_port.sv
module mbx_mcu_port
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 32
) (
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  input  logic [7:0]  mbx_rdata_i,
  output logic [7:0]  rdata_o,
  output mbx_req_t    req_o
);
  localparam logic [15:0] WIN_SIZE = 16'(NUM_MBX);
  logic [15:0] off;
  logic        in_win;

  assign off    = addr_i - MCU_WIN_BASE;
  assign in_win = (addr_i >= MCU_WIN_BASE) && (off < WIN_SIZE);

  always_comb begin
    req_o.we    = in_win && wr_i;
    req_o.re    = in_win && rd_i;
    req_o.idx   = off[7:0];
    req_o.wdata = wdata_i;
  end

  assign rdata_o = req_o.re ? mbx_rdata_i : '0;
endmodule

// File: rtl/mbx_store.sv
module mbx_store
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int H2M_IDX = 0,
  parameter int M2H_IDX = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mbx_req_t   h_req_i,
  input  mbx_req_t   m_req_i,
  output logic [7:0] h_rdata_o,
  output logic [7:0] m_rdata_o,
  output logic       mcu_irq_o,
  output logic       host_irq_o
);
  localparam int         IW    = (NUM_MBX > 1) ? $clog2(NUM_MBX) : 1;
  localparam logic [8:0] LIMIT = 9'(NUM_MBX);
  localparam logic [7:0] H2M   = 8'(H2M_IDX);
  localparam logic [7:0] M2H   = 8'(M2H_IDX);

  logic [7:0] mem_q [NUM_MBX];
  logic       h_ok, m_ok, collide;
  logic       h2m_set, h2m_clr, m2h_set, m2h_clr;
  logic       mcu_irq_q, host_irq_q;

  assign h_ok    = {1'b0, h_req_i.idx} < LIMIT;
  assign m_ok    = {1'b0, m_req_i.idx} < LIMIT;
  assign collide = h_req_i.we && h_ok && m_req_i.idx == h_req_i.idx;

  generate
    for (genvar i = 0; i < NUM_MBX; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[i] <= '0;
        else if (h_req_i.we && h_ok && h_req_i.idx == 8'(i))
          mem_q[i] <= h_req_i.wdata;
        else if (m_req_i.we && m_ok && m_req_i.idx == 8'(i))
          mem_q[i] <= m_req_i.wdata;
      end
    end
  endgenerate

  assign h_rdata_o = h_ok ? mem_q[h_req_i.idx[IW-1:0]] : '0;
  assign m_rdata_o = m_ok ? mem_q[m_req_i.idx[IW-1:0]] : '0;

  assign h2m_set = h_req_i.we && h_ok && h_req_i.idx == H2M;
  assign h2m_clr = m_req_i.re && m_ok && m_req_i.idx == H2M;
  assign m2h_set = m_req_i.we && m_ok && m_req_i.idx == M2H;
  assign m2h_clr = h_req_i.re && h_ok && h_req_i.idx == M2H;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcu_irq_q  <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      // set dominates a same-cycle clear
      if (h2m_set)      mcu_irq_q  <= 1'b1;
      else if (h2m_clr) mcu_irq_q  <= 1'b0;
      if (m2h_set)      host_irq_q <= 1'b1;
      else if (m2h_clr) host_irq_q <= 1'b0;
    end
  end

  assign mcu_irq_o  = mcu_irq_q;
  assign host_irq_o = host_irq_q;

  a_r7_mcu_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h2m_set |=> mcu_irq_o);
  a_r7_mcu_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h2m_clr && !h2m_set) |=> !mcu_irq_o);
  a_r8_host_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2h_set |=> host_irq_o);
  a_r8_host_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m2h_clr && !m2h_set) |=> !host_irq_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((h2m_set && h2m_clr) || (m2h_set && m2h_clr)) |=> (mcu_irq_o || host_irq_o));
  a_r9_host_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collide && m_req_i.we) |=> (mem_q[$past(h_req_i.idx[IW-1:0])] == $past(h_req_i.wdata)));
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int H2M_IDX = 0,
  parameter int M2H_IDX = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_idx_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic [15:0] host_addr_i,
  input  logic        host_rd_i,
  input  logic        host_wr_i,
  input  logic [7:0]  host_wdata_i,
  output logic [7:0]  host_rdata_o,
  output logic        host_hit_o,
  input  logic [15:0] mcu_addr_i,
  input  logic        mcu_rd_i,
  input  logic        mcu_wr_i,
  input  logic [7:0]  mcu_wdata_i,
  output logic [7:0]  mcu_rdata_o,
  output logic        mcu_irq_o,
  output logic        host_irq_o
);
  logic        enable;
  logic [15:0] base;
  mbx_req_t    h_req, m_req;
  logic [7:0]  h_mbx_rdata, m_mbx_rdata;

  mbx_cfg i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .enable_o(enable), .base_o(base)
  );

  mbx_host_port i_host (
    .clk_i, .rst_ni,
    .enable_i(enable), .base_i(base),
    .addr_i(host_addr_i), .rd_i(host_rd_i), .wr_i(host_wr_i), .wdata_i(host_wdata_i),
    .mbx_rdata_i(h_mbx_rdata), .hit_o(host_hit_o), .rdata_o(host_rdata_o), .req_o(h_req)
  );

  mbx_mcu_port #(.NUM_MBX(NUM_MBX)) i_mcu (
    .addr_i(mcu_addr_i), .rd_i(mcu_rd_i), .wr_i(mcu_wr_i), .wdata_i(mcu_wdata_i),
    .mbx_rdata_i(m_mbx_rdata), .rdata_o(mcu_rdata_o), .req_o(m_req)
  );

  mbx_store #(.NUM_MBX(NUM_MBX), .H2M_IDX(H2M_IDX), .M2H_IDX(M2H_IDX)) i_store (
    .clk_i, .rst_ni,
    .h_req_i(h_req), .m_req_i(m_req),
    .h_rdata_o(h_mbx_rdata), .m_rdata_o(m_mbx_rdata),
    .mcu_irq_o, .host_irq_o
  );

  a_r2_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable |-> !host_hit_o);
  a_r4_no_high_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_addr_i[15:12] != 4'h0) |-> !host_hit_o);
  a_r11_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rd_i |-> host_rdata_o == 8'h00) and (!mcu_rd_i |-> mcu_rdata_o == 8'h00));
endmodule

// File: tb/test_mbx_bridge.sv
`timescale 1ns/1ps
module test_mbx_bridge;
  localparam int N = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_idx = 0, cfg_wdata = 0, cfg_rdata;
  logic [15:0] host_addr = 16'hFFFF, mcu_addr = 0;
  logic        host_rd = 0, host_wr = 0, mcu_rd = 0, mcu_wr = 0;
  logic [7:0]  host_wdata = 0, mcu_wdata = 0, host_rdata, mcu_rdata;
  logic        host_hit, mcu_irq, host_irq;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit       m_en = 0, m_mirq = 0, m_hirq = 0;
  bit [7:0] m_hi = 0, m_lo = 0, m_idx = 0;
  int       m_mem [N];

  always #2 clk = ~clk;

  mbx_bridge i_mbx_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .host_addr_i(host_addr), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .host_hit_o(host_hit),
    .mcu_addr_i(mcu_addr), .mcu_rd_i(mcu_rd), .mcu_wr_i(mcu_wr), .mcu_wdata_i(mcu_wdata),
    .mcu_rdata_o(mcu_rdata), .mcu_irq_o(mcu_irq), .host_irq_o(host_irq)
  );

  function automatic bit f_hit(input logic [15:0] a);
    int base = {m_hi, m_lo};
    return m_en && (int'(a) < 4096) && (int'(a) / 2 == base / 2);
  endfunction

  function automatic int f_moff(input logic [15:0] a);
    return int'(a) - 32'h7F00;
  endfunction

  function automatic int f_cfg(input logic [7:0] i);
    if (i == 8'h30) return m_en;
    if (i == 8'h60) return m_hi;
    if (i == 8'h61) return m_lo;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update on the rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit hw, mw, hr, mr;
      int hi, mi;
      hi = m_idx;
      mi = f_moff(mcu_addr);
      hw = f_hit(host_addr) && host_wr && host_addr[0] && hi < N;
      hr = f_hit(host_addr) && host_rd && host_addr[0] && hi < N;
      mw = mcu_wr && mi >= 0 && mi < N;
      mr = mcu_rd && mi >= 0 && mi < N;
      if (f_hit(host_addr) && host_wr && !host_addr[0]) m_idx = host_wdata;
      if (mw && !(hw && hi == mi)) m_mem[mi] = mcu_wdata;
      if (hw) m_mem[hi] = host_wdata;
      if (hw && hi == 0) m_mirq = 1; else if (mr && mi == 0) m_mirq = 0;
      if (mw && mi == 1) m_hirq = 1; else if (hr && hi == 1) m_hirq = 0;
      if (cfg_we) begin
        if (cfg_idx == 8'h30) m_en = cfg_wdata[0];
        if (cfg_idx == 8'h60) m_hi = cfg_wdata;
        if (cfg_idx == 8'h61) m_lo = cfg_wdata & 8'hFE;
      end
    end
  end

  // compare every cycle, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int eh, em, mi;
      mi = f_moff(mcu_addr);
      eh = 0;
      if (f_hit(host_addr) && host_rd)
        eh = host_addr[0] ? ((m_idx < N) ? m_mem[m_idx] : 0) : m_idx;
      em = (mcu_rd && mi >= 0 && mi < N) ? m_mem[mi] : 0;
      chk(cur_req, host_hit, f_hit(host_addr), "host_hit (R2 R4 R11)");
      chk(cur_req, host_rdata, eh, "host_rdata (R5 R11)");
      chk(cur_req, mcu_rdata, em, "mcu_rdata (R6 R11)");
      chk(cur_req, mcu_irq, m_mirq, "mcu_irq (R7 R10)");
      chk(cur_req, host_irq, m_hirq, "host_irq (R8 R10)");
      chk(cur_req, cfg_rdata, f_cfg(cfg_idx), "cfg_rdata (R3)");
    end
  end

  task automatic clr();
    cfg_we = 0; host_rd = 0; host_wr = 0; mcu_rd = 0; mcu_wr = 0;
  endtask
  task automatic idle();
    @(negedge clk); clr(); host_addr = 16'hFFFF;
  endtask
  task automatic cfg_w(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); clr(); cfg_we = 1; cfg_idx = i; cfg_wdata = d;
  endtask
  task automatic h_w(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); clr(); host_addr = a; host_wr = 1; host_wdata = d;
  endtask
  task automatic h_r(input logic [15:0] a, input int exp, input string req);
    @(negedge clk); clr(); host_addr = a; host_rd = 1;
    #1 chk(req, host_rdata, exp, "directed host read");
  endtask
  task automatic m_w(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); clr(); mcu_addr = a; mcu_wr = 1; mcu_wdata = d;
  endtask
  task automatic m_r(input logic [15:0] a, input int exp, input string req);
    @(negedge clk); clr(); mcu_addr = a; mcu_rd = 1;
    #1 chk(req, mcu_rdata, exp, "directed mcu read");
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    idle();
    #1 chk("R1", {mcu_irq, host_irq}, 0, "irqs after reset");
    m_r(16'h7F00, 0, "R1");
    // R2 disabled: base 0 would otherwise match
    cur_req = "R2";
    h_w(16'h0000, 8'h02);
    h_w(16'h0001, 8'h55);
    #1 chk("R2", host_hit, 0, "hit while disabled");
    h_r(16'h0000, 0, "R2");
    m_r(16'h7F00, 0, "R2");
    m_r(16'h7F02, 0, "R2");
    // R3 configuration layout
    cur_req = "R3";
    cfg_w(8'h60, 8'h03);
    cfg_w(8'h61, 8'h41);
    cfg_w(8'h30, 8'hFF);
    @(negedge clk); clr(); cfg_idx = 8'h61;
    #1 chk("R3", cfg_rdata, 8'h40, "low byte bit0 forced");
    @(negedge clk); cfg_idx = 8'h30;
    #1 chk("R3", cfg_rdata, 8'h01, "enable readback");
    @(negedge clk); cfg_idx = 8'h31;
    #1 chk("R3", cfg_rdata, 0, "unused index");
    // R5 index/data ports at 0x0340/0x0341
    cur_req = "R5";
    h_w(16'h0341, 8'h00);
    h_w(16'h0340, 8'h05);
    h_r(16'h0340, 8'h05, "R5");
    h_w(16'h0341, 8'hA5);
    h_r(16'h0341, 8'hA5, "R5");
    h_w(16'h0340, 8'd40);
    h_w(16'h0341, 8'h77);
    h_r(16'h0341, 0, "R5");
    // R6 window
    cur_req = "R6";
    m_r(16'h7F05, 8'hA5, "R6");
    m_w(16'h7F20, 8'h99);
    m_r(16'h7F20, 0, "R6");
    m_w(16'h7EFF, 8'h98);
    m_r(16'h7EFF, 0, "R6");
    m_w(16'h7F1F, 8'h3C);
    m_r(16'h7F1F, 8'h3C, "R6");
    // R4 base above limit
    cur_req = "R4";
    cfg_w(8'h60, 8'h10);
    @(negedge clk); clr(); host_addr = 16'h1040; host_wr = 1; host_wdata = 8'h07;
    #1 chk("R4", host_hit, 0, "hit above 0x0FFF");
    h_r(16'h1041, 0, "R4");
    cfg_w(8'h60, 8'h03);
    // R7 doorbell to microcontroller
    cur_req = "R7";
    h_w(16'h0340, 8'h00);
    h_w(16'h0341, 8'h11);
    idle();
    #1 chk("R7", mcu_irq, 1, "set after host write");
    m_r(16'h7F00, 8'h11, "R7");
    idle();
    #1 chk("R7", mcu_irq, 0, "clear after mcu read");
    // R8 doorbell to host
    cur_req = "R8";
    m_w(16'h7F01, 8'h22);
    idle();
    #1 chk("R8", host_irq, 1, "set after mcu write");
    h_w(16'h0340, 8'h01);
    h_r(16'h0341, 8'h22, "R8");
    idle();
    #1 chk("R8", host_irq, 0, "clear after host read");
    // R9 collision
    cur_req = "R9";
    h_w(16'h0340, 8'h03);
    @(negedge clk); clr(); host_addr = 16'h0341; host_wr = 1; host_wdata = 8'hAA;
    mcu_addr = 16'h7F03; mcu_wr = 1; mcu_wdata = 8'hBB;
    m_r(16'h7F03, 8'hAA, "R9");
    // R10 set beats clear, both directions
    cur_req = "R10";
    h_w(16'h0340, 8'h00);
    h_w(16'h0341, 8'h31);
    @(negedge clk); clr(); host_addr = 16'h0341; host_wr = 1; host_wdata = 8'h32;
    mcu_addr = 16'h7F00; mcu_rd = 1;
    idle();
    #1 chk("R10", mcu_irq, 1, "mcu irq kept");
    h_w(16'h0340, 8'h01);
    @(negedge clk); clr(); host_addr = 16'h0341; host_rd = 1;
    mcu_addr = 16'h7F01; mcu_wr = 1; mcu_wdata = 8'h44;
    idle();
    #1 chk("R10", host_irq, 1, "host irq kept");
    // R11 mixed traffic, compared every cycle
    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); clr();
      case ($urandom_range(0, 3))
        0: host_addr = 16'h0340;
        1: host_addr = 16'h0341;
        2: host_addr = 16'h0341;
        default: host_addr = 16'($urandom_range(0, 16'h1FFF));
      endcase
      host_rd = 1'($urandom_range(0, 1));
      host_wr = !host_rd && ($urandom_range(0, 2) == 0);
      host_wdata = (host_addr == 16'h0340) ? 8'($urandom_range(0, 35)) : 8'($urandom);
      mcu_addr = 16'h7F00 + 16'($urandom_range(0, 36)) - 16'd2;
      mcu_rd = 1'($urandom_range(0, 1));
      mcu_wr = ($urandom_range(0, 2) == 0);
      mcu_wdata = 8'($urandom);
      if ($urandom_range(0, 60) == 0) begin
        cfg_we = 1; cfg_idx = 8'h30; cfg_wdata = 8'($urandom);
      end
    end
    cfg_w(8'h30, 8'h01);
    idle();
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule